// File: doc/BRIEF.md
# Destination Address Filter with Group Hash

This block decides, frame by frame, whether a receiver keeps an incoming frame. It looks only at the first six bytes of the frame, the destination address, as they stream in one byte per accepted beat. The decision is based on the address class (individual, group or all-ones broadcast), a programmed station address, a 64-entry group hash table and three enable bits taken from an 8-bit receive configuration word.

Group addresses are screened through a hash. A CRC-32 runs over the 48 destination bits, and six bits of the result select one entry of the table. The CRC is unrolled to eight bits per clock, so every accepted byte advances it by a full byte. The station address and the table are loaded through a byte-wide register write port. The verdict appears as a one-cycle strobe, together with an accept flag and a group flag that stay valid until the next verdict.

Top module: `dafilt_top`

## Requirements
- R1: While rst_n is low at a clock edge, and afterwards until the first verdict, dec_valid, dec_accept and dec_group read 0.
- R2: When rx_cfg bit 4 is 1, every frame is accepted, whatever its address.
- R3: An address of six 0xFF bytes is accepted only if rx_cfg bit 2 is 1 (or bit 4 is 1), and its dec_group reads 1.
- R4: Any other address whose first byte has bit 0 set is a group address and reports dec_group 1. Without bit 4 it is accepted only if rx_cfg bit 3 is 1 and its hash table entry is 1.
- R5: The hash index is bits 31..26 of a CRC. The CRC is seeded with 0xFFFFFFFF and consumes the address bits of byte 0 to byte 5, each byte least significant bit first. For each bit, carry = CRC[31] XOR the bit; the CRC shifts left by one; when carry is 1 the CRC is XORed with 0x04C11DB6 and bit 0 is set.
- R6: An address whose first byte has bit 0 clear reports dec_group 0. Without bit 4 it is accepted only when each of its six bytes equals station byte n, where n is its position (0 = first on the wire).
- R7: dec_valid is high for exactly one cycle per frame. It is sampled high at the second rising edge after the edge that captures the sixth address byte, and is low in the cycle between those two edges.
- R8: A byte is taken only when byte_vld is 1. Bytes with byte_first 0 are ignored outside a frame and after the sixth byte. byte_first 1 always restarts the address at byte 0, abandoning a partial address.
- R9: A write with reg_sel 0 stores reg_wdata as station byte reg_off (0..5); offsets 6 and 7 change nothing. A write with reg_sel 1 stores hash byte reg_off. Bit b of hash byte n is table entry 8*n+b, and entry k is selected by hash index k.
- R10: dec_accept and dec_group change only in the cycle where dec_valid is high, and keep their value until the next verdict.
- R11: The receive configuration is read at the edge that raises dec_valid. rx_cfg bits 0, 1, 5, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | Address byte present this cycle |
| byte_first | input | 1 | Marks the first byte of a frame |
| byte_data | input | 8 | Streamed destination address byte |
| rx_cfg | input | 8 | Receive configuration (bit 2 broadcast, bit 3 group, bit 4 accept all) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = station address byte, 1 = hash table byte |
| reg_off | input | 3 | Byte offset of the write |
| reg_wdata | input | 8 | Write data |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Frame accepted (held until next verdict) |
| dec_group | output | 1 | Destination is a group or broadcast address (held) |

## Verification
The bench builds the block with its default six-byte address and 64-entry table, with HASH_W = 6. Table and configuration are then small enough to cover completely. All 256 configuration words are run against a broadcast, a group, a matching and a non-matching individual address. Each of the eight hash bytes is driven as the only all-ones byte while 64 group addresses pass through, so every table position is compared with the arithmetic CRC model. Per-byte station mismatches, gapped streams, aborted addresses, stray bytes and ignored register offsets complete the coverage.

// File: rtl/dafilt_pkg.sv
// Package: shared constants, class type and the byte-wide hash CRC step.
// Assumes the configuration bit positions are fixed by the software view.
package dafilt_pkg;

    localparam logic [31:0] HASH_CRC_SEED = 32'hFFFF_FFFF;
    // Feedback constant with bit 0 folded in (the step always sets bit 0 on carry).
    localparam logic [31:0] HASH_CRC_POLY = 32'h04C1_1DB7;

    localparam int CFG_BCAST_BIT   = 2;
    localparam int CFG_MCAST_BIT   = 3;
    localparam int CFG_PROMISC_BIT = 4;

    typedef enum logic [1:0] {
        DST_UNICAST   = 2'd0,
        DST_GROUP     = 2'd1,
        DST_BROADCAST = 2'd2
    } dst_class_e;

    // Advance the hash CRC over one byte, least significant bit first.
    function automatic logic [31:0] hash_crc_byte(input logic [31:0] crc_in,
                                                  input logic [7:0]  data);
        logic [31:0] acc;
        logic        fb;
        acc = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb  = acc[31] ^ data[i];
            acc = {acc[30:0], 1'b0};
            if (fb) begin
                acc = acc ^ HASH_CRC_POLY;
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/dafilt_regs.sv
// Module: dafilt_regs
// Holds the station address bytes and the group hash table bytes, written
// one byte at a time. Assumes ADDR_BYTES and TBL_BYTES both fit in OFF_W
// bits of offset; offsets past ADDR_BYTES on the station side are dropped.
module dafilt_regs #(
    parameter int ADDR_BYTES = 6,
    parameter int TBL_BYTES  = 8,
    parameter int OFF_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_sel,
    input  logic [OFF_W-1:0]        wr_off,
    input  logic [7:0]              wr_data,
    output logic [8*ADDR_BYTES-1:0] station,
    output logic [8*TBL_BYTES-1:0]  hash_bits
);

    logic [7:0] sta_q [ADDR_BYTES];
    logic [7:0] tbl_q [TBL_BYTES];

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta
        // Station byte g: loaded by a station-side write at offset g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sta_q[g] <= '0;
            end else if (wr_en && !wr_sel && (wr_off == OFF_W'(g))) begin
                sta_q[g] <= wr_data;
            end
        end
        assign station[8*g +: 8] = sta_q[g];
    end

    for (genvar g = 0; g < TBL_BYTES; g++) begin : g_tbl
        // Hash byte g: loaded by a table-side write at offset g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_q[g] <= '0;
            end else if (wr_en && wr_sel && (wr_off == OFF_W'(g))) begin
                tbl_q[g] <= wr_data;
            end
        end
        assign hash_bits[8*g +: 8] = tbl_q[g];
    end

endmodule

// File: rtl/dafilt_seq.sv
// Module: dafilt_seq
// Tracks the position of the incoming byte within the destination address.
// A byte flagged first always restarts at lane 0; unflagged bytes count only
// while inside an address. Assumes ADDR_BYTES >= 2.
module dafilt_seq #(
    parameter int ADDR_BYTES = 6,
    parameter int LANE_W     = 3,
    parameter int CNT_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              byte_first,
    output logic              take,
    output logic [LANE_W-1:0] lane,
    output logic              last
);

    logic [CNT_W-1:0] cnt_q;
    logic             in_addr;

    // Inside an address: at least one byte taken, not all of them yet.
    assign in_addr = (cnt_q != '0) && (cnt_q < CNT_W'(ADDR_BYTES));
    assign take    = byte_vld && (byte_first || in_addr);
    assign lane    = byte_first ? '0 : LANE_W'(cnt_q);
    assign last    = take && (lane == LANE_W'(ADDR_BYTES - 1));

    // Count taken bytes; saturates at ADDR_BYTES until the next first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= CNT_W'(lane) + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dafilt_crc.sv
// Module: dafilt_crc
// Byte-parallel hash CRC: every taken byte advances the CRC by eight bit
// steps in one cycle; a first byte starts again from the seed.
module dafilt_crc
    import dafilt_pkg::*;
#(
    parameter int HASH_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              first,
    input  logic [7:0]        data,
    output logic [HASH_W-1:0] hash_idx
);

    logic [31:0] crc_q;
    logic [31:0] crc_base;

    assign crc_base = first ? HASH_CRC_SEED : crc_q;

    // CRC register: one unrolled byte step per taken byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= HASH_CRC_SEED;
        end else if (take) begin
            crc_q <= hash_crc_byte(crc_base, data);
        end
    end

    assign hash_idx = crc_q[31 -: HASH_W];

endmodule

// File: rtl/dafilt_cmp.sv
// Module: dafilt_cmp
// Accumulates, byte by byte, whether the address equals the station address
// and whether it is all ones, and captures the group bit of the first byte.
module dafilt_cmp #(
    parameter int ADDR_BYTES = 6,
    parameter int LANE_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    first,
    input  logic [LANE_W-1:0]       lane,
    input  logic [7:0]              data,
    input  logic [8*ADDR_BYTES-1:0] station,
    output logic                    uni_hit,
    output logic                    all_ones,
    output logic                    grp_bit
);

    logic [7:0] sta_byte;
    logic       uni_prev;
    logic       ones_prev;

    assign sta_byte  = station[8*lane +: 8];
    assign uni_prev  = first ? 1'b1 : uni_hit;
    assign ones_prev = first ? 1'b1 : all_ones;

    // Running equality against the station byte of the same lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uni_hit <= 1'b0;
        end else if (take) begin
            uni_hit <= uni_prev && (data == sta_byte);
        end
    end

    // Running all-ones test for broadcast detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            all_ones <= 1'b0;
        end else if (take) begin
            all_ones <= ones_prev && (data == 8'hFF);
        end
    end

    // Group bit: bit 0 of the first address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_bit <= 1'b0;
        end else if (take && first) begin
            grp_bit <= data[0];
        end
    end

endmodule

// File: rtl/dafilt_top.sv
// Module: dafilt_top
// Destination address filter. The address streams through a byte position
// tracker, a byte-parallel hash CRC and a comparator; one cycle after the
// last address byte is captured, the verdict is formed from the address
// class, the enables in rx_cfg and the hash table, and registered with a
// one-cycle strobe. Assumes ADDR_BYTES >= 2 and HASH_W >= 3.
module dafilt_top
    import dafilt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_W     = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic        byte_first,
    input  logic [7:0]  byte_data,
    input  logic [7:0]  rx_cfg,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [2:0]  reg_off,
    input  logic [7:0]  reg_wdata,
    output logic        dec_valid,
    output logic        dec_accept,
    output logic        dec_group
);

    localparam int TBL_BITS  = 1 << HASH_W;
    localparam int TBL_BYTES = TBL_BITS / 8;
    localparam int LANE_W    = $clog2(ADDR_BYTES);
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1);
    localparam int OFF_W     = 3;

    logic [8*ADDR_BYTES-1:0] station;
    logic [TBL_BITS-1:0]     hash_bits;
    logic                    take;
    logic [LANE_W-1:0]       lane;
    logic                    last;
    logic [HASH_W-1:0]       hash_idx;
    logic                    uni_hit;
    logic                    all_ones;
    logic                    grp_bit;
    logic                    pend_q;
    dst_class_e              cls;
    logic                    accept_d;

    dafilt_regs #(
        .ADDR_BYTES (ADDR_BYTES),
        .TBL_BYTES  (TBL_BYTES),
        .OFF_W      (OFF_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_sel    (reg_sel),
        .wr_off    (reg_off),
        .wr_data   (reg_wdata),
        .station   (station),
        .hash_bits (hash_bits)
    );

    dafilt_seq #(
        .ADDR_BYTES (ADDR_BYTES),
        .LANE_W     (LANE_W),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .byte_first (byte_first),
        .take       (take),
        .lane       (lane),
        .last       (last)
    );

    dafilt_crc #(
        .HASH_W (HASH_W)
    ) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .first    (byte_first),
        .data     (byte_data),
        .hash_idx (hash_idx)
    );

    dafilt_cmp #(
        .ADDR_BYTES (ADDR_BYTES),
        .LANE_W     (LANE_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .first    (byte_first),
        .lane     (lane),
        .data     (byte_data),
        .station  (station),
        .uni_hit  (uni_hit),
        .all_ones (all_ones),
        .grp_bit  (grp_bit)
    );

    // Remember that the last address byte was captured this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= last;
        end
    end

    // Classify the finished address: broadcast outranks group.
    always_comb begin
        if (all_ones) begin
            cls = DST_BROADCAST;
        end else if (grp_bit) begin
            cls = DST_GROUP;
        end else begin
            cls = DST_UNICAST;
        end
    end

    // Verdict from class, enables and the selected hash table entry.
    always_comb begin
        unique case (cls)
            DST_BROADCAST: accept_d = rx_cfg[CFG_BCAST_BIT];
            DST_GROUP:     accept_d = rx_cfg[CFG_MCAST_BIT] && hash_bits[hash_idx];
            default:       accept_d = uni_hit;
        endcase
        if (rx_cfg[CFG_PROMISC_BIT]) begin
            accept_d = 1'b1;
        end
    end

    // Register the strobe and the held verdict flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_group  <= 1'b0;
        end else begin
            dec_valid <= pend_q;
            if (pend_q) begin
                dec_accept <= accept_d;
                dec_group  <= grp_bit;
            end
        end
    end

endmodule

// File: rtl/dafilt_chk.sv
// Module: dafilt_chk
// Property checker for dafilt_top, bound to every instance. Keeps its own
// count of captured address bytes at the ports to time the verdict strobe.
module dafilt_chk
    import dafilt_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic       byte_first,
    input logic [7:0] rx_cfg,
    input logic       dec_valid,
    input logic       dec_accept,
    input logic       dec_group
);

    logic [7:0] seen_q;
    logic       sixth;
    logic       p1_q;
    logic       p2_q;

    assign sixth = byte_vld && !byte_first && (seen_q == 8'(ADDR_BYTES - 1));

    // Bytes seen since the last first byte, saturating past the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            p1_q   <= 1'b0;
            p2_q   <= 1'b0;
        end else begin
            if (byte_vld && byte_first) begin
                seen_q <= 8'd1;
            end else if (byte_vld && seen_q != 8'd0 && seen_q <= 8'(ADDR_BYTES)) begin
                seen_q <= seen_q + 8'd1;
            end
            p1_q <= sixth;
            p2_q <= p1_q;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);                                           // R7
    AST_NO_EARLY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> p2_q);                                                 // R7
    AST_NO_MISSED_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        p2_q |-> dec_valid);                                                 // R7
    AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && $past(rx_cfg[CFG_PROMISC_BIT]) |-> dec_accept);         // R2
    AST_GROUP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_group && dec_accept && !$past(rx_cfg[CFG_PROMISC_BIT])
        |-> $past(rx_cfg[CFG_BCAST_BIT]) || $past(rx_cfg[CFG_MCAST_BIT]));  // R4
    AST_HOLD_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> $stable(dec_accept));                                 // R10
    AST_HOLD_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> $stable(dec_group));                                  // R10

endmodule

bind dafilt_top dafilt_chk #(.ADDR_BYTES(ADDR_BYTES)) u_chk (.*);

// File: tb/sim_dafilt_top.sv
module sim_dafilt_top;

    localparam int AB = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic       byte_first = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [7:0] rx_cfg = 8'h00;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [2:0] reg_off = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic       dec_valid;
    logic       dec_accept;
    logic       dec_group;

    always #10 clk = ~clk;

    dafilt_top #(.ADDR_BYTES(AB), .HASH_W(6)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .byte_first (byte_first),
        .byte_data  (byte_data),
        .rx_cfg     (rx_cfg),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_off    (reg_off),
        .reg_wdata  (reg_wdata),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_group  (dec_group)
    );

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    logic [7:0] sta [AB];
    logic [7:0] tbl [8];

    // Count verdict strobes shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (dec_valid === 1'b1) pulses++;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    // Hash index from the CRC rule, bit by bit over the 48-bit address.
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c;
        logic        cy;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            cy = c[31] ^ a[i];
            c  = c << 1;
            if (cy) c = (c ^ 32'h04C1_1DB6) | 32'h1;
        end
        return c[31:26];
    endfunction

    function automatic logic [47:0] sta48();
        return mk(sta[0], sta[1], sta[2], sta[3], sta[4], sta[5]);
    endfunction

    function automatic logic ref_acc(input logic [47:0] a, input logic [7:0] cfg);
        logic [5:0] k;
        k = ref_idx(a);
        if (cfg[4]) return 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) return cfg[2];
        if (a[0]) return cfg[3] && tbl[k >> 3][k & 6'd7];
        return a == sta48();
    endfunction

    task automatic wr_reg(input logic sel, input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_off = off; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic load_tbl();
        for (int i = 0; i < 8; i++) wr_reg(1'b1, 3'(i), tbl[i]);
    endtask

    task automatic load_sta();
        for (int i = 0; i < AB; i++) wr_reg(1'b0, 3'(i), sta[i]);
    endtask

    // Stream one address and check strobe timing, verdict and hold.
    task automatic send(input logic [47:0] a, input logic [7:0] cfg,
                        input bit gap, input string req);
        logic acc;
        acc = ref_acc(a, cfg);
        for (int i = 0; i < AB; i++) begin
            @(negedge clk);
            rx_cfg = cfg;
            byte_vld = 1'b1; byte_first = (i == 0); byte_data = a[8*i +: 8];
            if (gap && i < AB - 1) begin
                @(negedge clk);
                byte_vld = 1'b0; byte_first = 1'b1; byte_data = 8'h5A;
            end
        end
        @(negedge clk);
        byte_vld = 1'b0; byte_first = 1'b0; byte_data = 8'hC3;
        check("R7", "strobe early", dec_valid, 1'b0);
        @(negedge clk);
        check("R7", "strobe", dec_valid, 1'b1);
        check(req, "accept", dec_accept, acc);
        check(req, "group", dec_group, a[0]);
        @(negedge clk);
        check("R7", "strobe width", dec_valid, 1'b0);
        check("R10", "accept held", dec_accept, acc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog expired: actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] a;
        logic [47:0] kinds [4];
        int p0;
        logic hold;

        sta[0] = 8'h02; sta[1] = 8'h1A; sta[2] = 8'h2B;
        sta[3] = 8'h3C; sta[4] = 8'h4D; sta[5] = 8'h5E;
        tbl[0] = 8'hA5; tbl[1] = 8'h3C; tbl[2] = 8'h0F; tbl[3] = 8'h96;
        tbl[4] = 8'hF0; tbl[5] = 8'h1E; tbl[6] = 8'h2D; tbl[7] = 8'h69;

        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", dec_valid, 1'b0);
        check("R1", "accept in reset", dec_accept, 1'b0);
        check("R1", "group in reset", dec_group, 1'b0);
        rst_n = 1'b1;

        // R8: bytes before any first marker are ignored.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            byte_vld = 1'b1; byte_first = 1'b0; byte_data = 8'hFF;
        end
        @(negedge clk); byte_vld = 1'b0;
        repeat (3) @(negedge clk);
        check("R8", "no verdict without first", pulses, 0);
        check("R1", "accept idle", dec_accept, 1'b0);

        load_sta();
        load_tbl();

        // R2 R3 R4 R6 R11: all configuration words against four classes.
        kinds[0] = 48'hFFFF_FFFF_FFFF;
        kinds[1] = mk(8'h01, 8'h00, 8'h5E, 8'h12, 8'h34, 8'h56);
        kinds[2] = sta48();
        kinds[3] = sta48() ^ 48'h0100_0000_0000;
        for (int c = 0; c < 256; c++) begin
            send(kinds[0], 8'(c), 1'b0, "R3");
            send(kinds[1], 8'(c), 1'b0, "R4");
            send(kinds[2], 8'(c), 1'b0, "R6");
            send(kinds[3], 8'(c), 1'b0, "R11");
        end

        // R5: hash index over 256 group addresses, mixed table.
        for (int v = 0; v < 256; v++)
            send(mk(8'h33, 8'h33, 8'h00, 8'h7F, 8'h00, 8'(v)), 8'h08, 1'b0, "R5");

        // R9: each hash byte alone set to all ones.
        for (int n = 0; n < 8; n++) begin
            for (int i = 0; i < 8; i++) tbl[i] = (i == n) ? 8'hFF : 8'h00;
            load_tbl();
            for (int v = 0; v < 64; v++)
                send(mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h11, 8'(v)), 8'h08, 1'b0, "R9");
        end

        // R9: station offsets 6 and 7 change neither station nor table.
        for (int i = 0; i < 8; i++) tbl[i] = 8'h00;
        load_tbl();
        wr_reg(1'b0, 3'd6, 8'hFF);
        wr_reg(1'b0, 3'd7, 8'hFF);
        for (int v = 0; v < 64; v++)
            send(mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h22, 8'(v)), 8'h08, 1'b0, "R9");
        send(sta48(), 8'h00, 1'b0, "R9");

        // R9: rewrite one station byte; old address now rejected.
        a = sta48();
        sta[3] = 8'hC7;
        wr_reg(1'b0, 3'd3, 8'hC7);
        send(a, 8'h0C, 1'b0, "R9");
        send(sta48(), 8'h0C, 1'b0, "R9");

        // R6: a mismatch in any single byte rejects.
        for (int i = 0; i < AB; i++) begin
            a = sta48() ^ (48'h80 << (8 * i));
            send(a, 8'h0C, 1'b0, "R6");
        end

        // R8: gaps between bytes with byte_vld low do not disturb.
        send(sta48(), 8'h00, 1'b1, "R8");
        send(48'hFFFF_FFFF_FFFF, 8'h04, 1'b1, "R8");

        // R8: bytes past the sixth are ignored.
        send(sta48(), 8'h00, 1'b0, "R8");
        p0 = pulses; hold = dec_accept;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            byte_vld = 1'b1; byte_first = 1'b0; byte_data = 8'h00;
        end
        @(negedge clk); byte_vld = 1'b0;
        repeat (4) @(negedge clk);
        check("R8", "extra bytes strobe", pulses - p0, 0);
        check("R8", "extra bytes accept", dec_accept, hold);

        // R8: a first byte restarts a partial address.
        p0 = pulses;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_vld = 1'b1; byte_first = (i == 0); byte_data = 8'hFF;
        end
        send(sta48(), 8'h00, 1'b0, "R8");
        check("R8", "restart strobes", pulses - p0, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule